// File: doc/BRIEF.md
# Dual-Edge Activity Watchdog

This block supervises a processor through a single activity line. Software flips the line at intervals, and the block treats either direction of change as a sign of life. If no change is seen for a programmable number of clock cycles, the active-low alarm output falls. That output is meant for the processor's non-maskable interrupt. A handler can then recover the stalled code.

The alarm stays low until the line changes again or until the system reset generator reports an active reset. While that reset status is active, the timer is held at zero, so the timeout window opens only once reset is released. A supply-low flag overrides everything: the alarm is forced low at once, whatever the timer holds. The activity line is brought into the clock domain by a synchronizer chain before edges are detected. The timeout counter stops at its limit and does not wrap.

Top module: `activity_watchdog`

## Requirements
- R1: With no activity and no reset status, `alarm_n` falls exactly `TIMEOUT_CYCLES` clock edges after the edge that last cleared the timer. It is high before that.
- R2: A low-to-high change on `act_in` clears the timer and returns `alarm_n` high.
- R3: A high-to-low change on `act_in` clears the timer and returns `alarm_n` high.
- R4: A pulse on `act_in` that lasts a single clock cycle counts as two edges. Each edge clears the timer, so the timeout is measured from the trailing edge.
- R5: With the default two synchronizer stages, a change of `act_in` that is driven before clock edge k clears the timer at edge k+2. `alarm_n` is high right after that edge.
- R6: While `rst_status` is high, the timer is held at zero and `alarm_n` stays high. The timeout counts from the first clock edge after `rst_status` falls.
- R7: While `supply_low` is high, `alarm_n` is low with no clock delay, whatever the state of the timer.
- R8: Once expired, the timer saturates, and `alarm_n` stays low for as long as there is no edge and no reset status.
- R9: `alarm_n` is active low. It is high as soon as `rst_n` is asserted low, and it is high after reset when `supply_low` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| act_in | input | 1 | Activity line toggled by the processor (asynchronous) |
| supply_low | input | 1 | Undervoltage flag; forces the alarm |
| rst_status | input | 1 | Active-reset status from the system reset generator |
| alarm_n | output | 1 | Active-low timeout alarm, meant for a non-maskable interrupt |

## Verification
Some properties are checked on every cycle. A clear from reset status or from a detected edge must leave the counter at zero on the next cycle. The counter must step by exactly one below its limit and hold at its limit. Any detected edge must raise the alarm on the next cycle unless the supply is low. An asserted alarm must persist while no clearing event occurs. Other behaviour needs the bench's scenarios: the exact number of cycles to timeout, the two-cycle synchronizer latency, a single-cycle pulse counting twice, and keepalive intervals on both sides of the timeout. The bench sweeps those intervals.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Bits needed to hold the values 0..limit
  function automatic int unsigned count_bits(input int unsigned limit);
    int unsigned w;
    w = 1;
    while ((64'd1 << w) <= 64'(limit)) w++;
    return w;
  endfunction

endpackage

// File: rtl/wdog_edge_sense.sv
module wdog_edge_sense #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  // Synchronizer chain: stage 0 samples the pin, the others shift
  assign sync_d[0] = din;
  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_chain
      assign sync_d[i] = sync_q[i-1];
    end
  endgenerate

  assign prev_d = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // Any level difference between the synchronized value and the stored one
  // is an edge, whatever its direction
  assign edge_o = sync_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/wdog_tmo_counter.sv
module wdog_tmo_counter
  import wdog_pkg::*;
#(
  parameter int unsigned LIMIT = 80_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired_o
);

  localparam int unsigned W = count_bits(LIMIT);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic         at_top;

  assign at_top = (cnt_q == TOP);

  always_comb begin
    cnt_en = clr | ~at_top;
    cnt_d  = clr ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = at_top;

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (cnt_q != TOP)) |=> (cnt_q == $past(cnt_q) + W'(1)));

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (cnt_q == TOP)) |=> (cnt_q == TOP));

endmodule

// File: rtl/activity_watchdog.sv
module activity_watchdog #(
  parameter int unsigned TIMEOUT_CYCLES = 80_000_000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_in,
  input  logic supply_low,
  input  logic rst_status,
  output logic alarm_n
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       act_edge;
  logic       tmr_clr;
  logic       expired;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  wdog_edge_sense #(
    .STAGES (SYNC_STAGES)
  ) u_sense (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .din    (act_in),
    .edge_o (act_edge)
  );

  assign tmr_clr = act_edge | rst_status;

  wdog_tmo_counter #(
    .LIMIT (TIMEOUT_CYCLES)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (tmr_clr),
    .expired_o (expired)
  );

  assign alarm_n = ~(expired | supply_low);

  // R2
  edge_release_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (act_edge && !rst_status) |=> (alarm_n || supply_low));

  // R8
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!alarm_n && !supply_low && !act_edge && !rst_status) |=> !alarm_n);

  // R6
  status_release_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_status |=> (alarm_n || supply_low));

endmodule

// File: tb/tb_activity_watchdog.sv
module tb_activity_watchdog;

  localparam int T = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic act_in;
  logic supply_low;
  logic rst_status;
  logic alarm_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  activity_watchdog #(
    .TIMEOUT_CYCLES (T),
    .SYNC_STAGES    (2)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_in     (act_in),
    .supply_low (supply_low),
    .rst_status (rst_status),
    .alarm_n    (alarm_n)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (alarm_n !== exp) begin
      fails++;
      $display("FAIL %s: alarm_n=%b expected=%b at %0t", req, alarm_n, exp, $time);
    end
  endtask

  // one posedge, then settle at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Posedge index of the last clear in the keepalive sweep: the reset pulse
  // clears at 0, a toggle driven in iteration p-2 clears at posedge p
  function automatic int last_clear(input int j, input int g);
    for (int p = j; p >= 3; p--) if ((p - 2) % g == 0) return p;
    return 0;
  endfunction

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, expected=finish");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; act_in = 1'b0; supply_low = 1'b0; rst_status = 1'b0;
    @(negedge clk); #1;
    check("R9 reset value", 1'b1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();

    // R6: status held for long, alarm must stay high, then timeout from release
    rst_status = 1'b1;
    for (int j = 1; j <= 3 * T; j++) begin step(); check("R6 held clear", 1'b1); end
    rst_status = 1'b0;
    for (int j = 1; j <= T + 4; j++) begin
      step();
      check("R1 R8 timeout after release", (j < T) ? 1'b1 : 1'b0);
    end

    // R2 + R5: rising edge from expired state
    act_in = 1'b1;
    for (int j = 1; j <= T + 5; j++) begin
      step();
      check("R2 R5 rising edge", (j >= 3 && (j - 3) < T) ? 1'b1 : 1'b0);
    end

    // R3: falling edge from expired state
    act_in = 1'b0;
    for (int j = 1; j <= T + 5; j++) begin
      step();
      check("R3 falling edge", (j >= 3 && (j - 3) < T) ? 1'b1 : 1'b0);
    end

    // R4: single-cycle pulse, trailing edge clears one cycle later
    act_in = 1'b1;
    for (int j = 1; j <= T + 6; j++) begin
      step();
      if (j == 1) act_in = 1'b0;
      check("R4 short pulse", (j >= 3 && (j - 4) < T) ? 1'b1 : 1'b0);
    end

    // R1 R2 R3: keepalive interval sweep on both sides of the timeout
    for (int g = 1; g <= T + 3; g++) begin
      rst_status = 1'b1;
      step();
      rst_status = 1'b0;
      for (int j = 1; j <= 3 * T + 4; j++) begin
        if (j % g == 0) act_in = ~act_in;
        step();
        check("R1 keepalive sweep", ((j - last_clear(j, g)) < T) ? 1'b1 : 1'b0);
      end
      repeat (3) step();
    end

    // R7: supply low forces the alarm on a fresh timer, without a clock edge
    rst_status = 1'b1;
    step();
    rst_status = 1'b0;
    step();
    check("R7 fresh timer high", 1'b1);
    supply_low = 1'b1; #1;
    check("R7 immediate force", 1'b0);
    act_in = ~act_in;
    for (int j = 1; j <= 4; j++) begin step(); check("R7 forced during edge", 1'b0); end
    supply_low = 1'b0; #1;
    check("R7 release after edge clear", 1'b1);

    // R6: status clears an expired timer at the next edge
    repeat (T + 2) step();
    check("R8 expired", 1'b0);
    rst_status = 1'b1;
    step();
    check("R6 status clears expired", 1'b1);
    rst_status = 1'b0;

    // R9: asynchronous reset clears an expired alarm at once
    repeat (T + 2) step();
    check("R8 expired again", 1'b0);
    rst_n = 1'b0; #1;
    check("R9 async reset", 1'b1);
    step();
    rst_n = 1'b1;
    step();
    check("R9 after reset", 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule